// File: doc/BRIEF.md
# Four-Phase Handshake Word Link

This block carries parallel data words from a sending clock domain to a receiving clock domain over a two-wire, return-to-zero handshake. The sending controller takes a word from a local valid/ready port, holds it on a shared data bus and runs the handshake. The receiving controller latches the bus into a one-word output register and offers it on a local valid/ready port. The two clocks may be unrelated. Each control wire is therefore re-timed through a chain of flip-flops before the far side acts on it.

A parameter fixes the order of the handshake. In the sender-led order, the sender raises its valid wire first and the receiver answers with an accepted wire. In the receiver-led order, the receiver first raises a ready-for-data wire to ask for a word, and the sender answers with valid. In both orders every wire returns low before the next word can start. The two handshake wires and the bus are also brought out as outputs, so that a system can observe the link.

Top module: `hs_link`

## Requirements
- R1: While `srcRstN` and `dstRstN` are low at a clock edge, `busValid`, `busAck` and `outValid` go low. In sender-led mode `inReady` is high after reset. In receiver-led mode `inReady` stays low until the receiver's ready-for-data has been seen.
- R2: In both modes, every word accepted on `inValid`/`inReady` appears exactly once on `outData` with `outValid` high. Words appear in the order they were accepted, with no bits changed.
- R3: In sender-led mode (`DEST_INIT`=0), `busAck` is the accepted wire. `busValid` rises only while the synchronized accepted wire is low. `busAck` rises only once the word is held in the output register. `busValid` falls only after accepted has been seen high. `busAck` falls only after valid has been seen low.
- R4: `busData` holds one value for as long as `busValid` is high. The new word is loaded into the bus register at least one source cycle before `busValid` rises.
- R5: Only one word is in flight at a time. `inReady` is low from the cycle after a word is accepted until the handshake for that word has returned to idle.
- R6: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values. While the register is full, the receiver gives no acknowledgement for a further word, so `busAck` stays low.
- R7: In receiver-led mode (`DEST_INIT`=1), `busAck` is the ready-for-data wire. The receiver raises it only when its register is empty and valid is seen low. The sender raises `busValid` only after it has seen ready high. The receiver drops ready once the word is captured. The sender drops `busValid` only after it has seen ready low.
- R8: Each side acts on the far side's control wire only after `SYNC_STAGES` (default 2) of its own clock edges. With the default, `busValid` falls no earlier than two source cycles after the triggering change on `busAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Sending-side clock |
| srcRstN | input | 1 | Synchronous active-low reset, sending side |
| inValid | input | 1 | A local word is offered |
| inReady | output | 1 | The sender accepts the offered word on this edge |
| inData | input | DATA_W | Local word to send |
| dstClk | input | 1 | Receiving-side clock |
| dstRstN | input | 1 | Synchronous active-low reset, receiving side |
| outValid | output | 1 | The output register holds a word |
| outReady | input | 1 | The local consumer takes the word |
| outData | output | DATA_W | The received word |
| busValid | output | 1 | Link valid wire, driven by the sender |
| busAck | output | 1 | Link accepted wire (sender-led) or ready-for-data wire (receiver-led), driven by the receiver |
| busData | output | DATA_W | Link data bus, driven by the sender |

## Verification
A controller stuck in a wrong state shows up as a stall on the link wires. The symptom is a `busValid` or `busAck` that never returns low, or an `inReady` that never comes back. It appears within a few source cycles of the next word, well inside one transfer's time. A wrong capture condition shows as a lost, repeated or corrupted word on `outData` at the very next consumer pop. Synchronizer chains that are too short show as `busValid` falling fewer than two source cycles after the acknowledge changes. The bench therefore watches the wire order and the reaction latency on every transfer in both modes.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;

  typedef struct packed {
    logic load;      // take inData into the bus register
  } srcStb_t;

  typedef struct packed {
    logic capture;   // copy the bus into the output register
    logic pop;       // local consumer takes the held word
  } dstStb_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_VALID,
    S_DROP
  } srcState_t;

  typedef enum logic [1:0] {
    D_IDLE,
    D_ARM,
    D_ACK,
    D_DONE
  } dstState_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
  import hs_link_pkg::*;
#(
  parameter bit DEST_INIT   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  input  logic    ackWire,
  output logic    busValid,
  output srcStb_t stb
);

  srcState_t state;
  logic      ackSync;
  logic      validQ;
  logic      raiseOk;
  logic      dropOk;
  logic      idleOk;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk (clk),
    .rstN(rstN),
    .d   (ackWire),
    .q   (ackSync)
  );

  generate
    if (DEST_INIT) begin : g_dstLed
      assign raiseOk = ackSync;     // ready-for-data seen
      assign dropOk  = !ackSync;    // receiver withdrew ready
      assign idleOk  = 1'b1;
    end else begin : g_srcLed
      assign raiseOk = !ackSync;    // previous accept returned to zero
      assign dropOk  = ackSync;     // accepted seen
      assign idleOk  = !ackSync;
    end
  endgenerate

  always_comb begin
    inReady  = (state == S_IDLE) && raiseOk;
    stb.load = inReady && inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      validQ <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE:  if (stb.load) state <= S_SETUP;
        S_SETUP: begin
          state  <= S_VALID;
          validQ <= 1'b1;
        end
        S_VALID: if (dropOk) begin
          state  <= S_DROP;
          validQ <= 1'b0;
        end
        S_DROP:  if (idleOk) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busValid = validQ;

  p_no_accept_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> !inReady);

  generate
    if (DEST_INIT) begin : g_chkDst
      p_valid_after_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busValid) |-> $past(ackSync));
      p_drop_after_unready_r7: assert property (@(posedge clk) disable iff (!rstN)
        $fell(busValid) |-> !$past(ackSync));
    end else begin : g_chkSrc
      p_valid_on_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(busValid) |-> !$past(ackSync));
      p_drop_after_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
        $fell(busValid) |-> $past(ackSync));
    end
  endgenerate

endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl
  import hs_link_pkg::*;
#(
  parameter bit DEST_INIT   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    validWire,
  input  logic    outFull,
  input  logic    outReady,
  output logic    ackWire,
  output dstStb_t stb
);

  dstState_t state;
  logic      validSync;
  logic      ackQ;

  hs_sync #(.STAGES(SYNC_STAGES)) u_validSync (
    .clk (clk),
    .rstN(rstN),
    .d   (validWire),
    .q   (validSync)
  );

  always_comb begin
    stb.pop     = outFull && outReady;
    stb.capture = 1'b0;
    if (DEST_INIT) stb.capture = (state == D_ARM) && validSync;
    else           stb.capture = (state == D_IDLE) && validSync && !outFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= D_IDLE;
      ackQ  <= 1'b0;
    end else begin
      unique case (state)
        D_IDLE: begin
          if (DEST_INIT) begin
            if (!outFull && !validSync) begin
              state <= D_ARM;
              ackQ  <= 1'b1;
            end
          end else if (stb.capture) begin
            state <= D_ACK;
            ackQ  <= 1'b1;
          end
        end
        D_ARM: if (stb.capture) begin
          state <= D_DONE;
          ackQ  <= 1'b0;
        end
        D_ACK: if (!validSync) begin
          state <= D_IDLE;
          ackQ  <= 1'b0;
        end
        D_DONE: if (!validSync) state <= D_IDLE;
        default: state <= D_IDLE;
      endcase
    end
  end

  assign ackWire = ackQ;

  generate
    if (DEST_INIT) begin : g_chkDst
      p_ready_on_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ackWire) |-> !$past(validSync) && !$past(outFull));
      p_unready_after_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
        $fell(ackWire) |-> outFull);
    end else begin : g_chkSrc
      p_ack_after_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ackWire) |-> outFull && $past(validSync));
      p_unack_after_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
        $fell(ackWire) |-> !$past(validSync));
    end
  endgenerate

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  srcStb_t           srcStb,
  input  logic [DATA_W-1:0] inData,
  input  logic              busValid,
  output logic [DATA_W-1:0] busData,
  input  logic              dstClk,
  input  logic              dstRstN,
  input  dstStb_t           dstStb,
  input  logic              outReady,
  output logic              outFull,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] busQ;
  logic [DATA_W-1:0] outQ;
  logic              fullQ;

  always_ff @(posedge srcClk) begin
    if (!srcRstN)         busQ <= '0;
    else if (srcStb.load) busQ <= inData;
  end

  always_ff @(posedge dstClk) begin
    if (!dstRstN) begin
      outQ  <= '0;
      fullQ <= 1'b0;
    end else if (dstStb.capture) begin
      outQ  <= busData;
      fullQ <= 1'b1;
    end else if (dstStb.pop) begin
      fullQ <= 1'b0;
    end
  end

  assign busData = busQ;
  assign outData = outQ;
  assign outFull = fullQ;

  p_bus_stable_r4: assert property (@(posedge srcClk) disable iff (!srcRstN)
    busValid |=> $stable(busData));

  p_hold_out_r6: assert property (@(posedge dstClk) disable iff (!dstRstN)
    outFull && !outReady |=> outFull && $stable(outData));

endmodule

// File: rtl/hs_link.sv
module hs_link
  import hs_link_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter bit DEST_INIT   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              dstClk,
  input  logic              dstRstN,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              busValid,
  output logic              busAck,
  output logic [DATA_W-1:0] busData
);

  srcStb_t srcStb;
  dstStb_t dstStb;
  logic    outFull;

  hs_src_ctrl #(.DEST_INIT(DEST_INIT), .SYNC_STAGES(SYNC_STAGES)) u_srcCtrl (
    .clk     (srcClk),
    .rstN    (srcRstN),
    .inValid (inValid),
    .inReady (inReady),
    .ackWire (busAck),
    .busValid(busValid),
    .stb     (srcStb)
  );

  hs_dst_ctrl #(.DEST_INIT(DEST_INIT), .SYNC_STAGES(SYNC_STAGES)) u_dstCtrl (
    .clk      (dstClk),
    .rstN     (dstRstN),
    .validWire(busValid),
    .outFull  (outFull),
    .outReady (outReady),
    .ackWire  (busAck),
    .stb      (dstStb)
  );

  hs_datapath #(.DATA_W(DATA_W)) u_datapath (
    .srcClk  (srcClk),
    .srcRstN (srcRstN),
    .srcStb  (srcStb),
    .inData  (inData),
    .busValid(busValid),
    .busData (busData),
    .dstClk  (dstClk),
    .dstRstN (dstRstN),
    .dstStb  (dstStb),
    .outReady(outReady),
    .outFull (outFull),
    .outData (outData)
  );

  assign outValid = outFull;

endmodule

// File: tb/hs_link_bench.sv
`timescale 1ns/100ps
module hs_link_bench;

  localparam int DW = 8;

  logic srcClk = 1'b0;
  logic dstClk = 1'b0;
  logic rstN   = 1'b0;
  always #2.5 srcClk = ~srcClk;   // 200 MHz
  always #3.5 dstClk = ~dstClk;

  // index 0: sender-led instance, index 1: receiver-led instance
  logic          inValid  [2];
  logic          inReady  [2];
  logic [DW-1:0] inData   [2];
  logic          outValid [2];
  logic          outReady [2];
  logic [DW-1:0] outData  [2];
  logic          busValid [2];
  logic          busAck   [2];
  logic [DW-1:0] busData  [2];

  hs_link #(.DATA_W(DW), .DEST_INIT(1'b0)) u_hs_link (
    .srcClk(srcClk), .srcRstN(rstN), .inValid(inValid[0]), .inReady(inReady[0]),
    .inData(inData[0]), .dstClk(dstClk), .dstRstN(rstN), .outValid(outValid[0]),
    .outReady(outReady[0]), .outData(outData[0]), .busValid(busValid[0]),
    .busAck(busAck[0]), .busData(busData[0]));

  hs_link #(.DATA_W(DW), .DEST_INIT(1'b1)) u_hs_link_dst (
    .srcClk(srcClk), .srcRstN(rstN), .inValid(inValid[1]), .inReady(inReady[1]),
    .inData(inData[1]), .dstClk(dstClk), .dstRstN(rstN), .outValid(outValid[1]),
    .outReady(outReady[1]), .outData(outData[1]), .busValid(busValid[1]),
    .busAck(busAck[1]), .busData(busData[1]));

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input int m, input logic [DW-1:0] w);
    @(negedge srcClk);
    inValid[m] = 1'b1;
    inData[m]  = w;
    while (!inReady[m]) @(negedge srcClk);
    @(negedge srcClk);
    inValid[m] = 1'b0;
  endtask

  task automatic recvWord(input int m, input int stall, output logic [DW-1:0] w);
    @(negedge dstClk);
    while (!outValid[m]) @(negedge dstClk);
    repeat (stall) @(negedge dstClk);
    w = outData[m];
    outReady[m] = 1'b1;
    @(negedge dstClk);
    outReady[m] = 1'b0;
  endtask

  // protocol monitors on the link wires, sampled mid source cycle
  int  r3Err = 0, r4Err = 0, r7Err = 0, r8Err = 0;
  logic          pValid [2] = '{1'b0, 1'b0};
  logic          pAck   [2] = '{1'b0, 1'b0};
  logic [DW-1:0] pData  [2] = '{'0, '0};
  int            trigCnt[2] = '{0, 0};

  always @(negedge srcClk) begin
    if (rstN) begin
      for (int m = 0; m < 2; m++) begin
        if (pValid[m] && busValid[m] && busData[m] !== pData[m]) r4Err++;
        if (m == 0) begin
          if (busValid[m] && !pValid[m] && busAck[m]) r3Err++;
          if (!busValid[m] && pValid[m] && !pAck[m]) r3Err++;
          if (!busAck[m] && pAck[m] && busValid[m]) r3Err++;
        end else begin
          if (busValid[m] && !pValid[m] && !busAck[m]) r7Err++;
          if (!busValid[m] && pValid[m] && busAck[m]) r7Err++;
          if (busAck[m] && !pAck[m] && busValid[m]) r7Err++;
        end
        if (pValid[m] && !busValid[m]) begin
          if (trigCnt[m] < 2) r8Err++;
          trigCnt[m] = 0;
        end else if (busValid[m] && ((m == 0) ? busAck[m] : !busAck[m] && pValid[m])) begin
          trigCnt[m]++;
        end
        pValid[m] = busValid[m];
        pAck[m]   = busAck[m];
        pData[m]  = busData[m];
      end
    end
  end

  // {mode, data, consumer stall}
  localparam logic [12:0] VECS [12] = '{
    {1'b0, 8'h3C, 4'd0}, {1'b0, 8'hFF, 4'd3}, {1'b0, 8'h00, 4'd1}, {1'b0, 8'h81, 4'd7},
    {1'b1, 8'h5A, 4'd0}, {1'b1, 8'hA5, 4'd5}, {1'b1, 8'h01, 4'd2}, {1'b1, 8'hFE, 4'd0},
    {1'b0, 8'h77, 4'd9}, {1'b1, 8'h80, 4'd4}, {1'b0, 8'h12, 4'd0}, {1'b1, 8'hC3, 4'd1}
  };
  localparam logic [DW-1:0] BURST [4] = '{8'h11, 8'h22, 8'h33, 8'h44};

  initial begin
    logic [DW-1:0] got;
    for (int m = 0; m < 2; m++) begin
      inValid[m] = 1'b0; inData[m] = '0; outReady[m] = 1'b0;
    end
    repeat (6) @(posedge srcClk);
    @(negedge srcClk);
    // R1: values under reset
    for (int m = 0; m < 2; m++) begin
      chk("R1 busValid", busValid[m], 0);
      chk("R1 busAck", busAck[m], 0);
      chk("R1 outValid", outValid[m], 0);
    end
    chk("R1 receiver-led inReady", inReady[1], 0);
    rstN = 1'b1;
    @(negedge srcClk);
    chk("R1 sender-led inReady", inReady[0], 1);
    repeat (10) @(negedge srcClk);
    // R7: receiver asks first, sender waits for a word
    chk("R7 ready raised", busAck[1], 1);
    chk("R7 inReady after ready", inReady[1], 1);
    chk("R7 no valid without word", busValid[1], 0);

    // R2: table walk across both modes and consumer stalls
    foreach (VECS[i]) begin
      automatic int mode = int'(VECS[i][12]);
      fork
        sendWord(mode, VECS[i][11:4]);
        recvWord(mode, int'(VECS[i][3:0]), got);
      join
      chk("R2 word delivered", got, VECS[i][11:4]);
    end

    // R2/R5: burst in sender-led mode, order kept
    fork
      begin
        for (int i = 0; i < 4; i++) sendWord(0, BURST[i]);
      end
      begin
        for (int i = 0; i < 4; i++) begin
          logic [DW-1:0] w;
          recvWord(0, 2 * i, w);
          chk("R2 burst order", w, BURST[i]);
        end
      end
    join

    // R6/R5: full output register blocks the next acknowledge
    sendWord(0, 8'hA1);
    sendWord(0, 8'hB2);
    repeat (40) @(negedge srcClk);
    chk("R6 outValid held", outValid[0], 1);
    chk("R6 outData held", outData[0], 8'hA1);
    chk("R6 no ack while full", busAck[0], 0);
    chk("R4 bus holds next word", busData[0], 8'hB2);
    chk("R5 no accept in flight", inReady[0], 0);
    recvWord(0, 0, got);
    chk("R6 first word", got, 8'hA1);
    recvWord(0, 0, got);
    chk("R6 second word", got, 8'hB2);

    repeat (20) @(negedge srcClk);
    chk("R3 sender-led wire order", r3Err, 0);
    chk("R4 bus stable while valid", r4Err, 0);
    chk("R7 receiver-led wire order", r7Err, 0);
    chk("R8 synchronizer latency", r8Err, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge srcClk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule